// File: doc/BRIEF.md
# Alarm-Driven Power-Off Controller

This block is the second alarm channel of a real-time clock. It holds its own set of six BCD match fields (seconds, minutes, hours, day, month, year). It compares them with the running calendar time each time the seconds value advances. On a full match it latches a status flag. The flag raises an interrupt when that interrupt is enabled.

When software has also granted the block control of the external power-enable pin, the same match drops that pin. This asks the power-management chip to cut supply. The pin then stays low until reset or until a power-up event is signalled.

Software arms a power-off by doing three things. It grants pin control. It writes the match fields for a moment about two seconds ahead of the current time, so the writes land before the next seconds update. It enables the interrupt. Register accesses are single-cycle word writes on a simple address/data bus, with combinational read data.

Top module: `pwroff_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1, `off_irq` is 0, and every register reads as zero.
- R2: The six match fields sit at offsets 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year). Each holds the low 8 bits of a write, and bits above 7 read as zero.
- R3: On a cycle with `sec_tick` high and all six fields of `time_bcd` equal to the match fields, status bit 7 at offset 0x44 reads 1 from the next cycle on.
- R4: A tick where any single field differs does not set the flag. A time vector that equals the match fields without `sec_tick` does not set it either.
- R5: Writing a word with bit 7 set to offset 0x44 clears the flag. Writing bit 7 as 0 leaves it alone. A match in the same cycle as a clearing write leaves the flag set.
- R6: Offset 0x48 stores write bits 2 to 4 together in one write, and its other bits read as zero. `off_irq` is high exactly while the flag and bit 4 of that register are both 1.
- R7: Offset 0x98 stores only bit 16 (pin control), and its other bits read as zero.
- R8: A match while bit 16 of 0x98 is 1 drives `pwr_en` to 0 in the cycle after the tick.
- R9: A match while bit 16 of 0x98 is 0 leaves `pwr_en` at 1, and it still sets the flag and can raise the interrupt.
- R10: Once low, `pwr_en` stays low through flag clears and pin-control clears. A `wake_evt` pulse returns it to 1 in the next cycle, and `wake_evt` takes priority over a match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse when the seconds value has advanced |
| time_bcd | input | 48 | Current time: year[47:40], month[39:32], day[31:24], hours[23:16], minutes[15:8], seconds[7:0] |
| wake_evt | input | 1 | Power-up event; returns the power-enable pin to ON |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| pwr_en | output | 1 | External power-enable pin, 1 = ON |
| off_irq | output | 1 | Power-off alarm interrupt |

## Verification
The bench builds the block with its default parameters: six 8-bit fields, an 8-bit offset bus and a 32-bit data word. With these values, pin control at bit 16 and the reserved upper bits of every register lie inside the word that is written and read back. The stimulus walks each field mismatch one at a time, ticks with and without pin control, and collides a flag-clearing write with a match. It then shows that the pin stays off through the register writes that might have released it, until a wake pulse arrives.

// File: rtl/pwroff_pkg.sv
// Shared offsets, bit positions and state type for the power-off controller.
package pwroff_pkg;
    localparam int OFS_MATCH_BASE = 'h80;
    localparam int OFS_STRIDE     = 4;
    localparam int OFS_STATUS     = 'h44;
    localparam int OFS_IRQ_EN     = 'h48;
    localparam int OFS_PIN_CTL    = 'h98;
    localparam int FLAG_BIT       = 7;
    localparam int IE_LO          = 2;
    localparam int IE_HI          = 4;
    localparam int IE_W           = IE_HI - IE_LO + 1;
    localparam int IE_OFF_IDX     = IE_HI - IE_LO;
    localparam int PIN_CTL_BIT    = 16;

    typedef enum logic {
        PIN_ON  = 1'b0,
        PIN_OFF = 1'b1
    } pin_state_e;
endpackage

// File: rtl/pwroff_match.sv
// Match-field bank: one writable BCD register per calendar field, compared
// against the live time vector. Assumes time_bcd is stable in the tick cycle.
module pwroff_match #(
    parameter int N_FIELDS = 6,
    parameter int FIELD_W  = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [FIELD_W-1:0]           wfield,
    input  logic                         sec_tick,
    input  logic [N_FIELDS*FIELD_W-1:0]  time_vec,
    output logic [N_FIELDS*FIELD_W-1:0]  fields_q,
    output logic                         hit
);
    import pwroff_pkg::*;

    logic [N_FIELDS-1:0] eq;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(OFS_MATCH_BASE + OFS_STRIDE * i);

        // Hold one match field; loaded by a write to its own offset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fields_q[i*FIELD_W +: FIELD_W] <= '0;
            else if (wr_en && addr == FADDR)
                fields_q[i*FIELD_W +: FIELD_W] <= wfield;
        end

        // Per-field equality against the running time.
        assign eq[i] = (fields_q[i*FIELD_W +: FIELD_W] == time_vec[i*FIELD_W +: FIELD_W]);
    end

    // A match counts only on a seconds update with every field equal.
    assign hit = sec_tick && (&eq);
endmodule

// File: rtl/pwroff_regs.sv
// Control and status: interrupt enables, pin-control grant and the sticky
// match flag (write-1-to-clear, set wins). Assumes one write per cycle.
module pwroff_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        hit,
    output logic                        flag_q,
    output logic [pwroff_pkg::IE_W-1:0] ie_q,
    output logic                        pin_ctl_q
);
    import pwroff_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = ADDR_W'(OFS_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_PIN_CTL = ADDR_W'(OFS_PIN_CTL);

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Interrupt enable group: all three bits replaced by one write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= '0;
        else if (wr_en && addr == A_IRQ_EN)
            ie_q <= wdata[IE_HI:IE_LO];
    end

    // Pin-control grant bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_ctl_q <= 1'b0;
        else if (wr_en && addr == A_PIN_CTL)
            pin_ctl_q <= wdata[PIN_CTL_BIT];
    end

    // Sticky match flag: a match overrides a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (wr_en && addr == A_STATUS && wdata[FLAG_BIT])
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/pwroff_pin_fsm.sv
// Power-enable pin state: ON after reset, OFF on a granted match, back ON
// only on a wake event. Wake has priority over a simultaneous match.
module pwroff_pin_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic pin_ctl,
    input  logic wake_evt,
    output logic pwr_en
);
    import pwroff_pkg::*;

    pin_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_ON:  if (!wake_evt && hit && pin_ctl) state_d = PIN_OFF;
            PIN_OFF: if (wake_evt)                   state_d = PIN_ON;
            default: state_d = PIN_ON;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIN_ON;
        else        state_q <= state_d;
    end

    assign pwr_en = (state_q == PIN_ON);
endmodule

// File: rtl/pwroff_ctrl.sv
// Top of the alarm power-off controller: match bank, control registers,
// pin state machine and the read-data mux. Assumes the calendar supplies
// time_bcd and a one-cycle sec_tick.
module pwroff_ctrl #(
    parameter int N_FIELDS = 6,
    parameter int FIELD_W  = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sec_tick,
    input  logic [N_FIELDS*FIELD_W-1:0] time_bcd,
    input  logic                        wake_evt,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        pwr_en,
    output logic                        off_irq
);
    import pwroff_pkg::*;

    localparam int VEC_W = N_FIELDS * FIELD_W;

    logic [VEC_W-1:0] fields_q;
    logic             hit;
    logic             flag_q;
    logic [IE_W-1:0]  ie_q;
    logic             pin_ctl_q;

    pwroff_match #(
        .N_FIELDS (N_FIELDS),
        .FIELD_W  (FIELD_W),
        .ADDR_W   (ADDR_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wfield   (bus_wdata[FIELD_W-1:0]),
        .sec_tick (sec_tick),
        .time_vec (time_bcd),
        .fields_q (fields_q),
        .hit      (hit)
    );

    pwroff_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .hit       (hit),
        .flag_q    (flag_q),
        .ie_q      (ie_q),
        .pin_ctl_q (pin_ctl_q)
    );

    pwroff_pin_fsm u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .pin_ctl  (pin_ctl_q),
        .wake_evt (wake_evt),
        .pwr_en   (pwr_en)
    );

    // Interrupt: latched flag gated by its enable bit.
    assign off_irq = flag_q && ie_q[IE_OFF_IDX];

    // Read-data mux; unmapped offsets and reserved bits return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS))  bus_rdata[FLAG_BIT]    = flag_q;
        if (bus_addr == ADDR_W'(OFS_IRQ_EN))  bus_rdata[IE_HI:IE_LO] = ie_q;
        if (bus_addr == ADDR_W'(OFS_PIN_CTL)) bus_rdata[PIN_CTL_BIT] = pin_ctl_q;
        for (int i = 0; i < N_FIELDS; i++) begin
            if (bus_addr == ADDR_W'(OFS_MATCH_BASE + OFS_STRIDE * i))
                bus_rdata[FIELD_W-1:0] = fields_q[i*FIELD_W +: FIELD_W];
        end
    end
endmodule

// File: rtl/pwroff_ctrl_chk.sv
// Property checker for pwroff_ctrl, attached by bind to its internal nets.
module pwroff_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic wake_evt,
    input logic hit,
    input logic pin_ctl,
    input logic flag,
    input logic ie_off,
    input logic pwr_en,
    input logic off_irq
);
    p_flag_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    p_no_flag_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !sec_tick) |=> !flag);

    p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_off |-> !off_irq);

    p_off_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pin_ctl && pwr_en && !wake_evt) |=> !pwr_en);

    p_stay_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !pin_ctl) |=> pwr_en);

    p_off_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !wake_evt) |=> !pwr_en);

    p_wake_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> pwr_en);
endmodule

bind pwroff_ctrl pwroff_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .wake_evt (wake_evt),
    .hit      (hit),
    .pin_ctl  (pin_ctl_q),
    .flag     (flag_q),
    .ie_off   (ie_q[pwroff_pkg::IE_OFF_IDX]),
    .pwr_en   (pwr_en),
    .off_irq  (off_irq)
);

// File: tb/pwroff_ctrl_test.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops and
// compares them at the falling edge.
module pwroff_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sec_tick;
    logic [47:0] time_bcd;
    logic        wake_evt;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        pwr_en;
    logic        off_irq;

    always #5 clk = ~clk;

    pwroff_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .time_bcd(time_bcd),
        .wake_evt(wake_evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en),
        .off_irq(off_irq)
    );

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    // Monitor: compare every queued expectation with the live outputs.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.sel)
                0:       act = {31'd0, pwr_en};
                1:       act = {31'd0, off_irq};
                default: act = bus_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic exp_pin(string req, logic v);
        q.push_back('{req, 0, {31'd0, v}});
        step();
    endtask

    task automatic exp_irq(string req, logic v);
        q.push_back('{req, 1, {31'd0, v}});
        step();
    endtask

    task automatic exp_reg(string req, logic [7:0] a, logic [31:0] v);
        bus_addr = a;
        q.push_back('{req, 2, v});
        step();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic tick(logic [47:0] t);
        time_bcd = t; sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
    endtask

    function automatic logic [7:0] fld(logic [47:0] t, int i);
        return t[i*8 +: 8];
    endfunction

    localparam logic [47:0] T_MATCH = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h58};

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sec_tick = 1'b0; time_bcd = '0; wake_evt = 1'b0;
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) step();
        rst_n = 1'b1;

        // R1: reset state
        exp_pin("R1 pwr_en after reset", 1'b1);
        exp_irq("R1 irq after reset", 1'b0);
        exp_reg("R1 status", 8'h44, 32'h0);
        exp_reg("R1 irq enable", 8'h48, 32'h0);
        exp_reg("R1 pin control", 8'h98, 32'h0);
        exp_reg("R1 seconds field", 8'h80, 32'h0);

        // R2: field placement and width
        for (int i = 0; i < 6; i++) wr(8'h80 + 8'(4 * i), {24'hFFFFFF, fld(T_MATCH, i)});
        for (int i = 0; i < 6; i++) exp_reg("R2 field readback", 8'h80 + 8'(4 * i), {24'h0, fld(T_MATCH, i)});

        // R6: enable group
        wr(8'h48, 32'hFFFF_FFFF);
        exp_reg("R6 enable reserved bits", 8'h48, 32'h1C);
        wr(8'h48, 32'h10);
        exp_reg("R6 enable group write", 8'h48, 32'h10);

        // R7: pin control
        wr(8'h98, 32'hFFFF_FFFF);
        exp_reg("R7 pin control only bit16", 8'h98, 32'h0001_0000);
        wr(8'h98, 32'h0);
        exp_reg("R7 pin control cleared", 8'h98, 32'h0);

        // R4: equal time without tick, then single-field mismatches
        time_bcd = T_MATCH;
        repeat (3) step();
        exp_reg("R4 no tick no flag", 8'h44, 32'h0);
        for (int i = 0; i < 6; i++) begin
            tick(T_MATCH ^ (48'h01 << (8 * i)));
            exp_reg("R4 one field differs", 8'h44, 32'h0);
        end

        // R3, R9, R6: match with pin control off
        tick(T_MATCH);
        exp_reg("R3 flag set on match", 8'h44, 32'h80);
        exp_pin("R9 pin stays on without control", 1'b1);
        exp_irq("R6 irq with enable", 1'b1);
        wr(8'h48, 32'h0C);
        exp_irq("R6 irq masked", 1'b0);
        wr(8'h48, 32'h10);

        // R5: clear semantics
        wr(8'h44, 32'h7F);
        exp_reg("R5 write zero bit7 keeps flag", 8'h44, 32'h80);
        wr(8'h44, 32'h80);
        exp_reg("R5 write one clears", 8'h44, 32'h0);
        exp_irq("R5 irq gone after clear", 1'b0);
        bus_wr = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h80;
        tick(T_MATCH);
        bus_wr = 1'b0;
        exp_reg("R5 set wins over clear", 8'h44, 32'h80);
        wr(8'h44, 32'h80);

        // R8: granted mismatch then granted match
        wr(8'h98, 32'h0001_0000);
        tick(T_MATCH ^ 48'h01);
        exp_pin("R8 mismatch keeps pin on", 1'b1);
        tick(T_MATCH);
        exp_pin("R8 pin off after match", 1'b0);
        exp_reg("R8 flag also set", 8'h44, 32'h80);

        // R10: sticky off, then wake
        wr(8'h44, 32'h80);
        wr(8'h98, 32'h0);
        repeat (4) step();
        exp_pin("R10 off survives clears", 1'b0);
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        exp_pin("R10 wake restores pin", 1'b1);

        // R10: wake beats a simultaneous match
        wr(8'h98, 32'h0001_0000);
        wake_evt = 1'b1;
        tick(T_MATCH);
        wake_evt = 1'b0;
        exp_pin("R10 wake priority over match", 1'b1);

        step();
        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule